// File: doc/BRIEF.md
# Dual-Bank Radio Decoder Register Interface

This block sits between a byte-level two-wire serial slave and an internal radio data decoder. The host side writes a small bank of three control bytes and reads a bank of seven status bytes. Each bank is addressed by its own auto-advancing pointer: a transfer start puts the selected pointer at byte 0, every transferred byte moves it on by one, and it stops at the last byte of its bank instead of wrapping.

The decoder side raises a block strobe each time a new data block has been received. On that strobe the status bank takes the new block word, decoder status, error status and quality byte, and the old block word moves into the previous-block slot. In the same cycle the control settings the host has left pending become the active settings that drive the decoder. Two of those settings, the quality-measurement trigger and the synchronization restart, reach the decoder as one-cycle pulses and are then dropped from the pending bank. While the host is reading, a block strobe is held back until the read ends, so the seven bytes of one read always belong to a single snapshot.

Top module: `radio_reg_bridge`

## Requirements
- R1: After reset every control output, every status byte and `host_rdata_o` read as zero.
- R2: A write-direction start puts the write pointer at control byte 0. Each `host_wr_i` stores `host_wdata_i` at the pointer and then advances it. The pointer stops at control byte 2, so a fourth byte overwrites byte 2.
- R3: A read-direction start puts the read pointer at status byte 0. Each `host_rd_i` loads `host_rdata_o` at the next clock edge and then advances the pointer. The pointer stops at status byte 6, so further reads return byte 6 again.
- R4: The status bytes in read order are: 0 decoder status, 1 block word bits 15:8, 2 block word bits 7:0, 3 previous word bits 15:8, 4 previous word bits 7:0, 5 error status, 6 signal quality.
- R5: The status bytes change only when a block event is applied. When it is applied, the last block word moves into the previous-word bytes and the new word and status bytes are loaded.
- R6: The control outputs change only when a block event is applied. They take the pending values held before that cycle, so a host write in the same cycle takes effect at the next applied event.
- R7: Control byte 0 is decoded as follows: bit 7 selects continuous (1) or triggered (0) quality measurement, bit 6 is the quality trigger, bit 5 is the synchronization restart, bits 4:3 give the sync-search correction mode, bit 2 selects RBDS (1) or RDS (0), and bits 1:0 give the output protocol. Control byte 1 drives `pause_fly_o` and control byte 2 drives `timing_sens_o`.
- R8: `qm_trig_o` and `sync_restart_o` go high for exactly the one cycle after an applied event whose pending byte 0 had bit 6 or bit 5 set. The applied event clears those pending bits unless the host writes byte 0 in that same cycle.
- R9: A block event that arrives between a read-direction start and the matching stop, the stop cycle included, is held back and applied in the cycle after the stop. If several events arrive during one read, only the latest is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start_i | input | 1 | Transfer start strobe from the serial slave |
| host_rd_dir_i | input | 1 | Direction of the transfer being started: 1 read, 0 write |
| host_stop_i | input | 1 | Transfer end strobe |
| host_wr_i | input | 1 | Byte write strobe |
| host_wdata_i | input | 8 | Byte written by the host |
| host_rd_i | input | 1 | Byte read strobe |
| host_rdata_o | output | 8 | Byte returned to the host, valid the cycle after the strobe |
| blk_evt_i | input | 1 | New data block strobe from the decoder |
| blk_word_i | input | 16 | Received block word |
| blk_stat_i | input | 8 | Decoder and data status byte |
| blk_err_i | input | 8 | Error status byte |
| blk_qual_i | input | 8 | Signal quality byte |
| qm_cont_o | output | 1 | Continuous quality measurement selected |
| qm_trig_o | output | 1 | One-cycle quality measurement trigger |
| sync_restart_o | output | 1 | One-cycle synchronization restart |
| ecc_mode_o | output | 2 | Sync-search error-correction mode |
| rbds_sel_o | output | 1 | RBDS mode selected |
| out_proto_o | output | 2 | Output protocol select |
| pause_fly_o | output | 8 | Pause level and flywheel setting |
| timing_sens_o | output | 8 | Pause time, oscillator and quality sensitivity setting |

## Verification
Two pairs of functions can land in the same clock cycle. A host write can meet a block event, and a host read burst can meet a block event. For the first pair, the bench drives a byte-0 write that sets the trigger bit in the same cycle as a block strobe. It then expects the old settings to be applied with no pulse, and the new trigger to pulse only at the following event. For the second pair, two block events are sent in the middle of a read burst. The bench expects the remaining bytes of that burst to come from the old snapshot, and the next burst to show only the later event, with the word that was current before the burst in the previous-word bytes.

// File: rtl/radio_reg_pkg.sv
package radio_reg_pkg;
  localparam int BYTE_W    = 8;
  localparam int CTL_REGS  = 3;
  localparam int STAT_REGS = 7;
  localparam int BLK_W     = 16;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic [BLK_W-1:0] word;
    byte_t            stat;
    byte_t            err;
    byte_t            qual;
  } blk_evt_t;

  // Field order matches control byte 0, bit 7 down to bit 0.
  typedef struct packed {
    logic       qm_cont;
    logic       qm_trig;
    logic       sync_rst;
    logic [1:0] ecc;
    logic       rbds;
    logic [1:0] proto;
  } mode_t;
endpackage

// File: rtl/reg_ptr.sv
module reg_ptr #(
  parameter int DEPTH = 3,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)
      ptr_d = '0;
    else if (step_i && (ptr_q != LAST))
      ptr_d = ptr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R2 R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && ptr_q == LAST) |=> (ptr_q == LAST));

  // R2 R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import radio_reg_pkg::*;
#(
  parameter int N = CTL_REGS,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  byte_t                     wdata_i,
  input  logic                      cap_i,
  output mode_t                     mode_o,
  output logic                      trig_o,
  output logic                      restart_o,
  output logic [N-2:0][BYTE_W-1:0]  aux_o
);
  localparam int TRIG_BIT = 6;
  localparam int RST_BIT  = 5;

  logic [N-1:0][BYTE_W-1:0] pend_q, pend_d;
  logic [N-2:0][BYTE_W-1:0] aux_q, aux_d;
  mode_t mode_q, mode_d;
  logic  trig_q, trig_d, rst_q, rst_d;
  logic  wr0;

  assign wr0 = wr_i && (wr_idx_i == '0);

  for (genvar g = 0; g < N; g++) begin : g_pend
    if (g == 0) begin : g_b0
      always_comb begin
        pend_d[g] = pend_q[g];
        if (wr0)
          pend_d[g] = wdata_i;
        else if (cap_i) begin
          pend_d[g][TRIG_BIT] = 1'b0;
          pend_d[g][RST_BIT]  = 1'b0;
        end
      end
    end else begin : g_bn
      always_comb begin
        pend_d[g] = pend_q[g];
        if (wr_i && (wr_idx_i == IDX_W'(g)))
          pend_d[g] = wdata_i;
      end
      always_comb aux_d[g-1] = cap_i ? pend_q[g] : aux_q[g-1];
    end
  end

  always_comb begin
    mode_d = mode_q;
    trig_d = 1'b0;
    rst_d  = 1'b0;
    if (cap_i) begin
      mode_d          = mode_t'(pend_q[0]);
      mode_d.qm_trig  = 1'b0;
      mode_d.sync_rst = 1'b0;
      trig_d          = pend_q[0][TRIG_BIT];
      rst_d           = pend_q[0][RST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      aux_q  <= '0;
      mode_q <= '0;
      trig_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      aux_q  <= aux_d;
      mode_q <= mode_d;
      trig_q <= trig_d;
      rst_q  <= rst_d;
    end
  end

  assign mode_o    = mode_q;
  assign trig_o    = trig_q;
  assign restart_o = rst_q;
  assign aux_o     = aux_q;

  // R8
  trig_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !wr0) |=> (!pend_q[0][TRIG_BIT] && !pend_q[0][RST_BIT]));

  // R6
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(mode_q) && $stable(aux_q)));
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import radio_reg_pkg::*;
#(
  parameter int N = STAT_REGS,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start_i,
  input  logic             stop_i,
  input  logic             evt_i,
  input  blk_evt_t         evt_data_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output byte_t            rdata_o,
  output logic             apply_o
);
  logic     rd_act_q, rd_act_d;
  logic     hold_vld_q, hold_vld_d;
  blk_evt_t hold_q, hold_d;
  blk_evt_t src;
  logic     apply;

  logic [BLK_W-1:0] last_q, last_d, prev_q, prev_d;
  byte_t dec_q, dec_d, err_q, err_d, qual_q, qual_d;
  byte_t rdata_q, rdata_d;
  byte_t view [N];

  always_comb begin
    rd_act_d = rd_act_q;
    if (stop_i)          rd_act_d = 1'b0;
    else if (rd_start_i) rd_act_d = 1'b1;
  end

  // Direct events win over a held one; a held one waits for the read to end.
  always_comb begin
    apply      = 1'b0;
    src        = evt_data_i;
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    if (evt_i && rd_act_q) begin
      hold_d     = evt_data_i;
      hold_vld_d = 1'b1;
    end else if (evt_i) begin
      apply      = 1'b1;
      hold_vld_d = 1'b0;
    end else if (hold_vld_q && !rd_act_q) begin
      apply      = 1'b1;
      src        = hold_q;
      hold_vld_d = 1'b0;
    end
  end

  always_comb begin
    last_d = last_q;
    prev_d = prev_q;
    dec_d  = dec_q;
    err_d  = err_q;
    qual_d = qual_q;
    if (apply) begin
      prev_d = last_q;
      last_d = src.word;
      dec_d  = src.stat;
      err_d  = src.err;
      qual_d = src.qual;
    end
  end

  always_comb begin
    view[0] = dec_q;
    view[1] = last_q[15:8];
    view[2] = last_q[7:0];
    view[3] = prev_q[15:8];
    view[4] = prev_q[7:0];
    view[5] = err_q;
    view[6] = qual_q;
    rdata_d = rd_i ? view[rd_idx_i] : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q   <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      last_q     <= '0;
      prev_q     <= '0;
      dec_q      <= '0;
      err_q      <= '0;
      qual_q     <= '0;
      rdata_q    <= '0;
    end else begin
      rd_act_q   <= rd_act_d;
      hold_vld_q <= hold_vld_d;
      hold_q     <= hold_d;
      last_q     <= last_d;
      prev_q     <= prev_d;
      dec_q      <= dec_d;
      err_q      <= err_d;
      qual_q     <= qual_d;
      rdata_q    <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign apply_o = apply;

  // R5
  shift_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (prev_q == $past(last_q)));

  // R9
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_q |=> ($stable(last_q) && $stable(dec_q) && $stable(qual_q)));

  // R9
  no_apply_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_q |-> !apply);
endmodule

// File: rtl/radio_reg_bridge.sv
module radio_reg_bridge
  import radio_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_start_i,
  input  logic        host_rd_dir_i,
  input  logic        host_stop_i,
  input  logic        host_wr_i,
  input  logic [7:0]  host_wdata_i,
  input  logic        host_rd_i,
  output logic [7:0]  host_rdata_o,
  input  logic        blk_evt_i,
  input  logic [15:0] blk_word_i,
  input  logic [7:0]  blk_stat_i,
  input  logic [7:0]  blk_err_i,
  input  logic [7:0]  blk_qual_i,
  output logic        qm_cont_o,
  output logic        qm_trig_o,
  output logic        sync_restart_o,
  output logic [1:0]  ecc_mode_o,
  output logic        rbds_sel_o,
  output logic [1:0]  out_proto_o,
  output logic [7:0]  pause_fly_o,
  output logic [7:0]  timing_sens_o
);
  localparam int WIDX_W = $clog2(CTL_REGS);
  localparam int RIDX_W = $clog2(STAT_REGS);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [WIDX_W-1:0] wr_idx;
  logic [RIDX_W-1:0] rd_idx;
  logic              wr_start, rd_start, apply;
  blk_evt_t          evt_data;
  mode_t             mode;
  logic [CTL_REGS-2:0][BYTE_W-1:0] aux;

  assign wr_start = host_start_i && !host_rd_dir_i;
  assign rd_start = host_start_i &&  host_rd_dir_i;
  assign evt_data = '{word: blk_word_i, stat: blk_stat_i, err: blk_err_i, qual: blk_qual_i};

  reg_ptr #(.DEPTH(CTL_REGS)) u_wptr (
    .clk(clk), .rst_n(rst_s_n), .clr_i(wr_start), .step_i(host_wr_i), .ptr_o(wr_idx));

  reg_ptr #(.DEPTH(STAT_REGS)) u_rptr (
    .clk(clk), .rst_n(rst_s_n), .clr_i(rd_start), .step_i(host_rd_i), .ptr_o(rd_idx));

  ctl_bank #(.N(CTL_REGS)) u_ctl (
    .clk(clk), .rst_n(rst_s_n), .wr_i(host_wr_i), .wr_idx_i(wr_idx),
    .wdata_i(host_wdata_i), .cap_i(apply), .mode_o(mode),
    .trig_o(qm_trig_o), .restart_o(sync_restart_o), .aux_o(aux));

  stat_bank #(.N(STAT_REGS)) u_stat (
    .clk(clk), .rst_n(rst_s_n), .rd_start_i(rd_start), .stop_i(host_stop_i),
    .evt_i(blk_evt_i), .evt_data_i(evt_data), .rd_i(host_rd_i), .rd_idx_i(rd_idx),
    .rdata_o(host_rdata_o), .apply_o(apply));

  assign qm_cont_o     = mode.qm_cont;
  assign ecc_mode_o    = mode.ecc;
  assign rbds_sel_o    = mode.rbds;
  assign out_proto_o   = mode.proto;
  assign pause_fly_o   = aux[0];
  assign timing_sens_o = aux[1];

  // R8
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (qm_trig_o || sync_restart_o) |-> $past(apply));

  // R6
  ctl_change_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(pause_fly_o) |-> $past(apply));

  // R1
  reset_rdata_chk: assert property (@(posedge clk)
    (!rst_s_n) |-> (host_rdata_o == 8'h00 && !qm_trig_o));
endmodule

// File: tb/radio_reg_bridge_tb_top.sv
module radio_reg_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_start_i = 0, host_rd_dir_i = 0, host_stop_i = 0, host_wr_i = 0, host_rd_i = 0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic blk_evt_i = 0;
  logic [15:0] blk_word_i = '0;
  logic [7:0] blk_stat_i = '0, blk_err_i = '0, blk_qual_i = '0;
  logic qm_cont_o, qm_trig_o, sync_restart_o, rbds_sel_o;
  logic [1:0] ecc_mode_o, out_proto_o;
  logic [7:0] pause_fly_o, timing_sens_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] model [7];
  logic mon_arm = 0;

  always #4 clk = ~clk;  // 125 MHz

  radio_reg_bridge dut_i (.*);

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Scoreboard monitor: a strobe seen at an edge yields data checked at the next negedge.
  always @(posedge clk) mon_arm <= host_rd_i;
  always @(negedge clk) begin
    if (mon_arm) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected read got=%h exp=none", host_rdata_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({8'h00, host_rdata_o}, {8'h00, e}, t);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic start_xfer(input bit rd);
    host_start_i = 1; host_rd_dir_i = rd; tick(); host_start_i = 0;
  endtask
  task automatic stop_xfer();
    host_stop_i = 1; tick(); host_stop_i = 0;
  endtask
  task automatic wr_byte(input logic [7:0] b);
    host_wr_i = 1; host_wdata_i = b; tick(); host_wr_i = 0;
  endtask
  task automatic rd_byte(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    host_rd_i = 1; tick(); host_rd_i = 0;
  endtask
  task automatic model_apply(input logic [15:0] w, input logic [7:0] s, e, q);
    model[3] = model[1]; model[4] = model[2];
    model[0] = s; model[1] = w[15:8]; model[2] = w[7:0]; model[5] = e; model[6] = q;
  endtask
  task automatic set_evt(input logic [15:0] w, input logic [7:0] s, e, q);
    blk_word_i = w; blk_stat_i = s; blk_err_i = e; blk_qual_i = q; blk_evt_i = 1;
  endtask
  task automatic evt(input logic [15:0] w, input logic [7:0] s, e, q);
    set_evt(w, s, e, q); tick(); blk_evt_i = 0;
  endtask
  task automatic read_all(input string t);
    start_xfer(1);
    for (int i = 0; i < 7; i++) rd_byte(model[i], t);
    tick();
    stop_xfer();
  endtask

  initial begin
    for (int i = 0; i < 7; i++) model[i] = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk({qm_cont_o, qm_trig_o, sync_restart_o, rbds_sel_o, ecc_mode_o, out_proto_o}, 0, "R1 ctl");
    chk({pause_fly_o, timing_sens_o}, 0, "R1 aux");
    read_all("R1 status");

    // R2 write three bytes; R6 not applied before event
    start_xfer(0);
    wr_byte(8'hEE); wr_byte(8'h5A); wr_byte(8'hC3);
    stop_xfer();
    chk({pause_fly_o, timing_sens_o}, 0, "R6 before event");
    evt(16'hBEEF, 8'h11, 8'h22, 8'h33);
    model_apply(16'hBEEF, 8'h11, 8'h22, 8'h33);
    // R7 decode of 8'hEE: cont=1 trig=1 rst=1 ecc=01 rbds=1 proto=10
    chk({qm_cont_o, ecc_mode_o, rbds_sel_o, out_proto_o}, {1'b1, 2'b01, 1'b1, 2'b10}, "R7 mode");
    chk({pause_fly_o, timing_sens_o}, 16'h5AC3, "R7 aux");
    chk({qm_trig_o, sync_restart_o}, 2'b11, "R8 pulse high");
    tick();
    chk({qm_trig_o, sync_restart_o}, 2'b00, "R8 pulse one cycle");
    chk(qm_cont_o, 1, "R6 held");

    // R4 order, R3 saturation at byte 6
    start_xfer(1);
    for (int i = 0; i < 7; i++) rd_byte(model[i], "R4 order");
    rd_byte(model[6], "R3 saturate");
    rd_byte(model[6], "R3 saturate");
    tick();
    stop_xfer();

    // R8 pending bits cleared; R5 shift
    evt(16'h1234, 8'h44, 8'h55, 8'h66);
    model_apply(16'h1234, 8'h44, 8'h55, 8'h66);
    chk({qm_trig_o, sync_restart_o}, 2'b00, "R8 self-clear");
    read_all("R5 shift");
    chk(model[3], 8'hBE, "R5 model");

    // R2 write saturation
    start_xfer(0);
    wr_byte(8'h01); wr_byte(8'h02); wr_byte(8'h03); wr_byte(8'h04);
    stop_xfer();
    evt(16'hABCD, 8'h77, 8'h88, 8'h99);
    model_apply(16'hABCD, 8'h77, 8'h88, 8'h99);
    chk({pause_fly_o, timing_sens_o}, 16'h0204, "R2 saturate");
    chk({qm_cont_o, ecc_mode_o, rbds_sel_o, out_proto_o}, 6'b000001, "R2 byte0");

    // R9 deferral with two events during a read
    start_xfer(1);
    rd_byte(model[0], "R9 snap");
    rd_byte(model[1], "R9 snap");
    evt(16'h0F0F, 8'hA1, 8'hA2, 8'hA3);
    evt(16'hF0F0, 8'hB1, 8'hB2, 8'hB3);
    for (int i = 2; i < 7; i++) rd_byte(model[i], "R9 snap");
    tick();
    stop_xfer();
    repeat (2) tick();
    model_apply(16'hF0F0, 8'hB1, 8'hB2, 8'hB3);
    read_all("R9 latest");

    // R6 write and event in the same cycle
    start_xfer(0);
    host_wr_i = 1; host_wdata_i = 8'h40;
    set_evt(16'h5555, 8'hC1, 8'hC2, 8'hC3);
    tick();
    host_wr_i = 0; blk_evt_i = 0;
    model_apply(16'h5555, 8'hC1, 8'hC2, 8'hC3);
    chk({qm_trig_o, out_proto_o}, {1'b0, 2'b01}, "R6 same-cycle old");
    stop_xfer();
    evt(16'h6666, 8'hD1, 8'hD2, 8'hD3);
    model_apply(16'h6666, 8'hD1, 8'hD2, 8'hD3);
    chk({qm_trig_o, sync_restart_o, out_proto_o}, 4'b1000, "R8 later pulse");
    read_all("R5 after same-cycle");

    repeat (3) tick();
    chk(exp_q.size(), 0, "R3 scoreboard drained");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule